// File: doc/BRIEF.md
# ISA Target Ready Responder

This block runs the target side of the handshake when an external bus master on an ISA bus accesses local memory or a local register. The two command strobes (read and write, both active low) arrive without any relation to the local clock. They pass through a two-flop synchroniser, and the block looks for a falling edge on either of them. If that edge comes while the external master owns the bus and the address decodes to this target, the block pulls the channel-ready line low, which stretches the cycle with wait states.

The line stays low until local logic reports that read data is on the bus or that write data has been captured. The block then drives the line high for a fixed time of about 70 ns, counted in whole clock cycles and rounded up, and then lets it float. If the master drops its command or gives up the bus before that report arrives, the line is released at once. For local memory hits the block also drives the 16-bit memory select low. Each tri-state output is split into a value pin and an output-enable pin, and the pad logic outside the block combines them. The handshake inputs are single-cycle strobes with no back-pressure.

Top module: `isa_target_ready`

## Requirements
- R1: While reset is held, and after it until a qualifying command edge, both output enables (`chrdy_oe_o`, `memcs16_oe_o`) are 0.
- R2: A falling edge on `ior_n_i` or `iow_n_i`, while `master_own_i` and `hit_i` are both 1, enables the ready line driven low (`chrdy_oe_o`=1, `chrdy_o`=0). This happens at the third rising clock edge after the command pin falls.
- R3: The ready line stays driven low for as long as neither `rd_data_rdy_i` nor `wr_latched_i` is seen high.
- R4: A strobe on `rd_data_rdy_i` or `wr_latched_i` during the low phase makes the ready line driven high from the next clock edge. It stays driven high for exactly PULSE_CYC = ceil(PULSE_PS / CLK_PS) cycles (14 with the defaults).
- R5: When the high pulse ends, `chrdy_oe_o` returns to 0. A command that is still held low does not start another cycle; a new falling edge is needed.
- R6: When `hit_i` or `master_own_i` is 0 at the command edge, the ready line is never enabled, and strobes on `rd_data_rdy_i` and `wr_latched_i` have no effect.
- R7: If the command deasserts (both command pins high) before a strobe arrives, `chrdy_oe_o` drops to 0 at the third clock edge after the command pin rises.
- R8: `memcs16_oe_o` is 1 one cycle after `master_own_i`, `hit_i` and `mem_hit_i` are all 1, and 0 otherwise. `memcs16_n_o` is 0 whenever it is enabled.
- R9: If `master_own_i` goes to 0 during the low phase or the high pulse, `chrdy_oe_o` is 0 from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_own_i | input | 1 | External master owns the bus (synchronous) |
| hit_i | input | 1 | Current address decodes to this target |
| mem_hit_i | input | 1 | The hit is local memory, not a register |
| ior_n_i | input | 1 | ISA I/O read command, active low, asynchronous |
| iow_n_i | input | 1 | ISA I/O write command, active low, asynchronous |
| rd_data_rdy_i | input | 1 | Read data placed on the bus (one-cycle strobe) |
| wr_latched_i | input | 1 | Write data captured (one-cycle strobe) |
| chrdy_o | output | 1 | Channel-ready value |
| chrdy_oe_o | output | 1 | Channel-ready output enable |
| memcs16_n_o | output | 1 | 16-bit memory select value, active low |
| memcs16_oe_o | output | 1 | 16-bit memory select output enable |

## Verification
Random transactions choose read or write, target or non-target, memory or register hit, a wait length from zero to several cycles, and whether the command is dropped before the strobe. Target cycles with strobes confirm the exact pulse length and that the line floats afterwards. Dropped commands and ownership loss show that both release paths are separate from the pulse timer. Non-target cycles that still receive strobes show that the line stays released. A command held low past the pulse shows that the block waits for a new edge and does not retrigger on the level. The memory-select enable is compared on every cycle against the decode inputs, so register hits and memory hits are told apart.

// File: rtl/isa_rdy_pkg.sv
package isa_rdy_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_HOLD  = 2'd1,
    RS_PULSE = 2'd2
  } rdy_state_e;
endpackage

// File: rtl/isa_rdy_sync.sv
module isa_rdy_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/isa_rdy_timer.sv
module isa_rdy_timer #(
  parameter int CYCLES = 14,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (abort_i)  cnt_q <= '0;
    else if (start_i)  cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && !abort_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/isa_target_ready.sv
module isa_target_ready
  import isa_rdy_pkg::*;
#(
  parameter int CLK_PS   = 5000,
  parameter int PULSE_PS = 70000,
  localparam int PULSE_CYC = (PULSE_PS + CLK_PS - 1) / CLK_PS,
  localparam int RW = $clog2(PULSE_CYC + 2) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_own_i,
  input  logic hit_i,
  input  logic mem_hit_i,
  input  logic ior_n_i,
  input  logic iow_n_i,
  input  logic rd_data_rdy_i,
  input  logic wr_latched_i,
  output logic chrdy_o,
  output logic chrdy_oe_o,
  output logic memcs16_n_o,
  output logic memcs16_oe_o
);
  logic [1:0] cmd_s;
  logic       cmd_act, cmd_prev_q, cmd_fall, strobe;
  logic       tmr_start, tmr_abort, tmr_busy, tmr_last;
  logic       cs_oe_q;
  rdy_state_e st_q, st_d;

  isa_rdy_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({iow_n_i, ior_n_i}), .sync_o(cmd_s)
  );

  assign cmd_act  = ~cmd_s[0] | ~cmd_s[1];
  assign cmd_fall = cmd_act & ~cmd_prev_q;
  assign strobe   = rd_data_rdy_i | wr_latched_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_prev_q <= 1'b0;
    else        cmd_prev_q <= cmd_act;
  end

  isa_rdy_timer #(.CYCLES(PULSE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start_i(tmr_start), .abort_i(tmr_abort),
    .busy_o(tmr_busy), .last_o(tmr_last)
  );

  always_comb begin
    st_d      = st_q;
    tmr_start = 1'b0;
    tmr_abort = 1'b0;
    unique case (st_q)
      RS_IDLE:
        if (cmd_fall && master_own_i && hit_i) st_d = RS_HOLD;
      RS_HOLD:
        if (!master_own_i || !cmd_act) st_d = RS_IDLE;
        else if (strobe) begin
          st_d      = RS_PULSE;
          tmr_start = 1'b1;
        end
      RS_PULSE:
        if (!master_own_i) begin
          st_d      = RS_IDLE;
          tmr_abort = 1'b1;
        end else if (tmr_last || !tmr_busy) st_d = RS_IDLE;
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_oe_q <= 1'b0;
    else        cs_oe_q <= master_own_i & hit_i & mem_hit_i;
  end

  assign chrdy_oe_o   = (st_q != RS_IDLE);
  assign chrdy_o      = (st_q == RS_PULSE);
  assign memcs16_oe_o = cs_oe_q;
  assign memcs16_n_o  = 1'b0;

  // checker: length of the driven-high run
  logic [RW-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run_q <= '0;
    else if (chrdy_oe_o && chrdy_o) hi_run_q <= hi_run_q + 1'b1;
    else hi_run_q <= '0;
  end

  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= RW'(PULSE_CYC)); // R4
  AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chrdy_oe_o) |-> $past(master_own_i && hit_i)); // R2
  AST_HIGH_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chrdy_o) && chrdy_oe_o) |-> $past(rd_data_rdy_i || wr_latched_i)); // R3
  AST_NO_DRIVE_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !master_own_i |=> !chrdy_oe_o); // R9
  AST_CS16_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    memcs16_oe_o |-> $past(master_own_i && hit_i && mem_hit_i)); // R8
endmodule

// File: tb/isa_target_ready_test.sv
module isa_target_ready_test;
  localparam int CLK_PS = 5000;
  localparam int PULSE_CYC = (70000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic own = 0, hit = 0, mem = 0, rd_n = 1, wr_n = 1, rdy = 0, wlat = 0;
  logic chrdy, chrdy_oe, cs_n, cs_oe;
  int n_chk = 0, n_bad = 0;
  logic exp_cs;

  always #2.5ns clk = ~clk;

  isa_target_ready uut (
    .clk(clk), .rst_n(rst_n), .master_own_i(own), .hit_i(hit), .mem_hit_i(mem),
    .ior_n_i(rd_n), .iow_n_i(wr_n), .rd_data_rdy_i(rdy), .wr_latched_i(wlat),
    .chrdy_o(chrdy), .chrdy_oe_o(chrdy_oe), .memcs16_n_o(cs_n), .memcs16_oe_o(cs_oe)
  );

  function automatic logic cs_expect(logic o, logic h, logic m);
    return o & h & m;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock; the memory-select enable is compared every cycle (R8)
  task automatic tick();
    exp_cs = cs_expect(own, hit, mem);
    @(posedge clk); #1;
    if (rst_n) begin
      chk("R8 cs16 enable", cs_oe, exp_cs);
      if (cs_oe) chk("R8 cs16 level", cs_n, 0);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cmd(logic is_rd, logic lvl);
    if (is_rd) rd_n = lvl; else wr_n = lvl;
  endtask

  task automatic strobe(logic is_rd);
    if (is_rd) rdy = 1; else wlat = 1;
    tick();
    rdy = 0; wlat = 0;
  endtask

  // target transaction: wait d cycles, then strobe or drop the command
  task automatic target_txn(logic is_rd, int d, logic drop, logic m);
    own = 1; hit = 1; mem = m;
    cmd(is_rd, 0);
    ticks(2);
    chk("R2 not yet driven", chrdy_oe, 0);
    tick();
    chk("R2 driven oe", chrdy_oe, 1);
    chk("R2 driven low", chrdy, 0);
    for (int i = 0; i < d; i++) begin
      tick();
      chk("R3 wait held low", {chrdy_oe, chrdy}, 2'b10);
    end
    if (drop) begin
      cmd(is_rd, 1);
      ticks(2);
      chk("R7 still low before release", chrdy_oe, 1);
      tick();
      chk("R7 released after drop", chrdy_oe, 0);
    end else begin
      int n = 0;
      strobe(is_rd);
      while (chrdy_oe && chrdy && n < 64) begin n++; tick(); end
      chk("R4 pulse length", n, PULSE_CYC);
      chk("R5 floated after pulse", chrdy_oe, 0);
      ticks(3);
      chk("R5 no retrigger on level", chrdy_oe, 0);
      cmd(is_rd, 1);
    end
    ticks(3);
  endtask

  task automatic nontarget_txn(logic is_rd, logic o, logic h);
    own = o; hit = h; mem = $urandom_range(0, 1);
    cmd(is_rd, 0);
    ticks(3);
    chk("R6 not driven", chrdy_oe, 0);
    strobe(is_rd);
    ticks(2);
    chk("R6 strobe ignored", chrdy_oe, 0);
    cmd(is_rd, 1);
    ticks(3);
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'h5EED_1234));
        #1;
        chk("R1 reset ready oe", chrdy_oe, 0);
        chk("R1 reset cs16 oe", cs_oe, 0);
        ticks(3);
        rst_n = 1;
        ticks(2);
        chk("R1 idle ready oe", chrdy_oe, 0);
        // strobe while idle has no effect (R6)
        own = 1; hit = 1;
        strobe(1);
        ticks(2);
        chk("R6 idle strobe ignored", chrdy_oe, 0);
        // directed corners
        target_txn(1, 0, 0, 1);
        target_txn(0, 5, 0, 0);
        target_txn(1, 2, 1, 1);
        nontarget_txn(0, 1, 0);
        nontarget_txn(1, 0, 1);
        // ownership lost while holding low (R9)
        own = 1; hit = 1; mem = 0; rd_n = 0;
        ticks(4);
        chk("R9 holding before loss", chrdy_oe, 1);
        own = 0;
        tick();
        chk("R9 released on ownership loss", chrdy_oe, 0);
        rd_n = 1; ticks(3);
        // ownership lost during high pulse (R9)
        own = 1; hit = 1; wr_n = 0;
        ticks(3);
        strobe(0);
        ticks(3);
        chk("R9 pulse active", {chrdy_oe, chrdy}, 2'b11);
        own = 0;
        tick();
        chk("R9 pulse cut on loss", chrdy_oe, 0);
        wr_n = 1; ticks(3);
        // random mix
        for (int k = 0; k < 60; k++) begin
          logic is_rd = 1'($urandom_range(0, 1));
          if ($urandom_range(0, 3) == 0)
            nontarget_txn(is_rd, 1'($urandom_range(0, 1)), 1'b0);
          else
            target_txn(is_rd, $urandom_range(0, 6),
                       1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
        end
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule